// File: doc/BRIEF.md
# Call/Return Stack with Program Counter

This block holds the program counter of a small microcontroller core together with an eight-level hardware stack of return addresses. The decoder drives one-cycle strobes: advance, jump, subroutine call, plain return, return with an 8-bit literal, return from interrupt and interrupt entry. The block then moves the program counter and pushes or pops the stack to match. Only the top entry of the stack can be reached. There is no path to read or write the stack from memory.

Interrupt entry saves the resume address and masks further interrupts by clearing the global enable. The dedicated interrupt return restores that enable while it pops. A return that carries a literal also pulses a load strobe towards the working register for one cycle. Misuse of the stack is recorded in two sticky flags. One marks a return taken with an empty stack. The other marks a push that overwrote the oldest entry. Every output is registered and changes on the clock edge that follows the strobe.

Top module: `cs_retstack`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `pc`, `gie`, `w_load`, `w_value` and both flags to 0 and empties the stack. All stack entries read as 0 after reset.
- R2: `step` sets `pc` to `pc`+1 modulo 2^13, so 8191 is followed by 0. The stack is not touched.
- R3: `jump` loads `target` into `pc` and leaves the stack unchanged.
- R4: `call` pushes `pc`+1 (modulo 2^13) and loads `target` into `pc`.
- R5: `ret` pops the top entry into `pc`. Nested calls return in last-in, first-out order.
- R6: `ret_lit` pops like R5. It also raises `w_load` for exactly one cycle with `w_value` equal to `literal`. `w_value` holds its value in every other cycle.
- R7: `int_req` pushes the current `pc` without incrementing it, loads `int_vector` into `pc` and clears `gie`.
- R8: `ret_int` pops like R5 and sets `gie` to 1.
- R9: A pop with an empty stack still moves the pointer down with wraparound and loads the entry found there into `pc`. It also sets `stk_underflow`, which stays set until reset.
- R10: A push while eight entries are held overwrites the oldest entry and sets `stk_overflow`, which stays set until reset. The following eight pops return the eight newest addresses, newest first.
- R11: When several strobes are high together, one is honoured, in this order of precedence: `int_req`, `call`, `jump`, `ret_int`, `ret_lit`, `ret`, `step`. With no strobe high, `pc` holds.
- R12: Every output changes on the clock edge at which the strobe is sampled, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance the program counter by one |
| jump | input | 1 | Load `target` into the program counter |
| call | input | 1 | Push the return address and load `target` |
| ret | input | 1 | Pop into the program counter |
| ret_lit | input | 1 | Pop and deliver `literal` to the working register |
| ret_int | input | 1 | Pop and set the global interrupt enable |
| int_req | input | 1 | Interrupt entry: push, load `int_vector`, mask |
| target | input | 13 | Jump or call destination |
| int_vector | input | 13 | Interrupt entry address |
| literal | input | 8 | Value carried by a return with literal |
| pc | output | 13 | Current program counter |
| w_load | output | 1 | One-cycle load strobe for the working register |
| w_value | output | 8 | Literal for the working register |
| gie | output | 1 | Global interrupt enable |
| stk_underflow | output | 1 | Sticky: a pop found the stack empty |
| stk_overflow | output | 1 | Sticky: a push overwrote the oldest entry |

## Verification
The bench builds the block with its defaults: a 13-bit program counter, eight stack levels and an 8-bit literal. Because the stack is only eight deep, a directed run of nine calls reaches the overwrite case, and nine returns after it reach the wrapped underflow read. The full 13-bit width also puts the 8191-to-0 wrap of the advance path within reach of a single jump. A long stretch of random, often overlapping strobes, with periodic resets, then exercises the precedence order against a behavioural model.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADV,
        OP_JMP,
        OP_CALL,
        OP_IRQ,
        OP_RET,
        OP_RETL,
        OP_RETI
    } cs_op_e;

    typedef struct packed {
        logic adv;
        logic jmp;
        logic call;
        logic ret;
        logic retl;
        logic reti;
        logic irq;
    } cs_req_t;

    // Precedence: interrupt, call, jump, interrupt return, literal return,
    // plain return, advance.
    function automatic cs_op_e pick_op(cs_req_t r);
        if (r.irq)       return OP_IRQ;
        else if (r.call) return OP_CALL;
        else if (r.jmp)  return OP_JMP;
        else if (r.reti) return OP_RETI;
        else if (r.retl) return OP_RETL;
        else if (r.ret)  return OP_RET;
        else if (r.adv)  return OP_ADV;
        else             return OP_NONE;
    endfunction

    function automatic logic op_pushes(cs_op_e op);
        return (op == OP_CALL) || (op == OP_IRQ);
    endfunction

    function automatic logic op_pops(cs_op_e op);
        return (op == OP_RET) || (op == OP_RETL) || (op == OP_RETI);
    endfunction

endpackage

// File: rtl/cs_op_sel.sv
module cs_op_sel
    import cs_pkg::*;
(
    input  cs_req_t req,
    output cs_op_e  op,
    output logic    do_push,
    output logic    do_pop
);
    always_comb begin
        op      = pick_op(req);
        do_push = op_pushes(op);
        do_pop  = op_pops(op);
    end
endmodule

// File: rtl/cs_lifo.sv
module cs_lifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         uflow,
    output logic         oflow
);
    // DEPTH is a power of two so the pointer wraps on its own.
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (push && sp == PTR_W'(i))
                q <= push_data;
        end
        assign slot[i] = q;
    end

    assign rd_ptr   = sp - 1'b1;
    assign top_data = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= '0;
            cnt   <= '0;
            uflow <= 1'b0;
            oflow <= 1'b0;
        end else if (push) begin
            sp <= sp + 1'b1;
            if (cnt == FULL) oflow <= 1'b1;
            else             cnt   <= cnt + 1'b1;
        end else if (pop) begin
            sp <= rd_ptr;
            if (cnt == '0) uflow <= 1'b1;
            else           cnt   <= cnt - 1'b1;
        end
    end

    a_r9_uflow_sticky: assert property (@(posedge clk) disable iff (rst)
        uflow |=> uflow);
    a_r10_oflow_sticky: assert property (@(posedge clk) disable iff (rst)
        oflow |=> oflow);
    a_r9_empty_pop_flags: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && cnt == '0) |=> uflow);
    a_r10_full_push_flags: assert property (@(posedge clk) disable iff (rst)
        (push && cnt == FULL) |=> oflow);
    a_r11_single_port_op: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/cs_flow.sv
module cs_flow
    import cs_pkg::*;
#(
    parameter int unsigned PC_W  = 13,
    parameter int unsigned LIT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cs_op_e           op,
    input  logic [PC_W-1:0]  tgt,
    input  logic [PC_W-1:0]  vec,
    input  logic [LIT_W-1:0] lit,
    input  logic [PC_W-1:0]  top_data,
    output logic [PC_W-1:0]  push_data,
    output logic [PC_W-1:0]  pc,
    output logic             gie,
    output logic             w_ld,
    output logic [LIT_W-1:0] w_val
);
    logic [PC_W-1:0] pc_inc;
    assign pc_inc    = pc + PC_W'(1);
    // Interrupt entry saves the instruction not yet run; a call saves the next one.
    assign push_data = (op == OP_IRQ) ? pc : pc_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            gie   <= 1'b0;
            w_ld  <= 1'b0;
            w_val <= '0;
        end else begin
            w_ld <= 1'b0;
            unique case (op)
                OP_ADV:  pc <= pc_inc;
                OP_JMP:  pc <= tgt;
                OP_CALL: pc <= tgt;
                OP_IRQ: begin
                    pc  <= vec;
                    gie <= 1'b0;
                end
                OP_RET:  pc <= top_data;
                OP_RETL: begin
                    pc    <= top_data;
                    w_ld  <= 1'b1;
                    w_val <= lit;
                end
                OP_RETI: begin
                    pc  <= top_data;
                    gie <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r2_step_increments: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADV) |=> pc == $past(pc) + PC_W'(1));
    a_r3_jump_target: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JMP) |=> pc == $past(tgt));
    a_r4_call_target: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CALL) |=> pc == $past(tgt));
    a_r6_literal_strobe: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RETL) |=> (w_ld && w_val == $past(lit)));
    a_r6_literal_holds: assert property (@(posedge clk) disable iff (rst)
        (op != OP_RETL) |=> (!w_ld && $stable(w_val)));
    a_r7_irq_masks: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IRQ) |=> !gie);
    a_r8_reti_unmasks: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RETI) |=> gie);
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NONE) |=> $stable(pc));
endmodule

// File: rtl/cs_retstack.sv
module cs_retstack
    import cs_pkg::*;
#(
    parameter int unsigned PC_W  = 13,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LIT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             jump,
    input  logic             call,
    input  logic             ret,
    input  logic             ret_lit,
    input  logic             ret_int,
    input  logic             int_req,
    input  logic [PC_W-1:0]  target,
    input  logic [PC_W-1:0]  int_vector,
    input  logic [LIT_W-1:0] literal,
    output logic [PC_W-1:0]  pc,
    output logic             w_load,
    output logic [LIT_W-1:0] w_value,
    output logic             gie,
    output logic             stk_underflow,
    output logic             stk_overflow
);
    cs_req_t         req;
    cs_op_e          op;
    logic            do_push;
    logic            do_pop;
    logic [PC_W-1:0] push_data;
    logic [PC_W-1:0] top_data;

    assign req = '{adv: step, jmp: jump, call: call, ret: ret,
                   retl: ret_lit, reti: ret_int, irq: int_req};

    cs_op_sel u_sel (
        .req     (req),
        .op      (op),
        .do_push (do_push),
        .do_pop  (do_pop)
    );

    cs_lifo #(.DEPTH(DEPTH), .W(PC_W)) u_lifo (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (push_data),
        .top_data  (top_data),
        .uflow     (stk_underflow),
        .oflow     (stk_overflow)
    );

    cs_flow #(.PC_W(PC_W), .LIT_W(LIT_W)) u_flow (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .tgt       (target),
        .vec       (int_vector),
        .lit       (literal),
        .top_data  (top_data),
        .push_data (push_data),
        .pc        (pc),
        .gie       (gie),
        .w_ld      (w_load),
        .w_val     (w_value)
    );

    a_r5_pop_loads_top: assert property (@(posedge clk) disable iff (rst)
        do_pop |=> pc == $past(top_data));
    a_r7_irq_vector: assert property (@(posedge clk) disable iff (rst)
        int_req |=> pc == $past(int_vector));
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == '0 && !gie && !w_load && !stk_underflow && !stk_overflow));
endmodule

// File: tb/tb_cs_retstack.sv
`timescale 1ns/1ps
module tb_cs_retstack;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 0, jump = 0, call = 0, ret = 0, ret_lit = 0, ret_int = 0, int_req = 0;
    logic [12:0] target = '0, int_vector = '0;
    logic [7:0]  literal = '0;
    logic [12:0] pc;
    logic        w_load, gie, stk_underflow, stk_overflow;
    logic [7:0]  w_value;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cs_retstack dut (
        .clk(clk), .rst(rst), .step(step), .jump(jump), .call(call), .ret(ret),
        .ret_lit(ret_lit), .ret_int(ret_int), .int_req(int_req), .target(target),
        .int_vector(int_vector), .literal(literal), .pc(pc), .w_load(w_load),
        .w_value(w_value), .gie(gie), .stk_underflow(stk_underflow),
        .stk_overflow(stk_overflow)
    );

    // Behavioural reference model
    int    mstk [8];
    int    msp, mcnt, mpc, mwval;
    bit    mgie, mwld, muf, mof;
    string mtag = "R1";

    task automatic m_push(int v);
        mstk[msp] = v;
        msp = (msp + 1) % 8;
        if (mcnt == 8) begin mof = 1; mtag = "R10"; end
        else mcnt++;
    endtask

    task automatic m_pop();
        if (mcnt == 0) begin muf = 1; mtag = "R9"; end
        else mcnt--;
        msp = (msp + 7) % 8;
        mpc = mstk[msp];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) mstk[i] = 0;
            msp = 0; mcnt = 0; mpc = 0; mwval = 0;
            mgie = 0; mwld = 0; muf = 0; mof = 0; mtag = "R1";
        end else begin
            mwld = 0;
            if (int_req) begin
                mtag = "R7"; m_push(mpc); mpc = int_vector; mgie = 0;
            end else if (call) begin
                mtag = "R4"; m_push((mpc + 1) % 8192); mpc = target;
            end else if (jump) begin
                mtag = "R3"; mpc = target;
            end else if (ret_int) begin
                mtag = "R8"; m_pop(); mgie = 1;
            end else if (ret_lit) begin
                mtag = "R6"; m_pop(); mwld = 1; mwval = literal;
            end else if (ret) begin
                mtag = "R5"; m_pop();
            end else if (step) begin
                mtag = "R2"; mpc = (mpc + 1) % 8192;
            end else begin
                mtag = "R11";
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // R12: outputs compared half a cycle after every edge against the model
    task automatic compare_all();
        chk(mtag, "pc", int'(pc), mpc);
        chk(mtag, "gie", int'(gie), int'(mgie));
        chk(mtag, "w_load", int'(w_load), int'(mwld));
        chk(mtag, "w_value", int'(w_value), mwval);
        chk(mtag, "stk_underflow", int'(stk_underflow), int'(muf));
        chk(mtag, "stk_overflow", int'(stk_overflow), int'(mof));
    endtask

    task automatic clear_in();
        step = 0; jump = 0; call = 0; ret = 0; ret_lit = 0; ret_int = 0; int_req = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        clear_in();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) tick();
        rst = 0;
        // R1: reset state
        chk("R1", "pc after reset", int'(pc), 0);
        chk("R1", "gie after reset", int'(gie), 0);
        // R2: step and 13-bit wrap
        step = 1; tick();
        step = 1; tick();
        jump = 1; target = 13'd8191; tick();
        step = 1; tick();
        chk("R2", "wrap to zero", int'(pc), 0);
        // R4/R10: nine nested calls, the ninth overwrites the oldest
        for (int i = 0; i < 9; i++) begin
            call = 1; target = 13'(100 * (i + 1)); tick();
        end
        chk("R10", "overflow flag", int'(stk_overflow), 1);
        // R5/R9: nine returns; the last one underflows
        for (int i = 0; i < 9; i++) begin
            ret = 1; tick();
        end
        chk("R9", "underflow flag", int'(stk_underflow), 1);
        rst = 1; tick(); rst = 0;
        // R7/R8/R6: interrupt entry, literal return and interrupt return
        jump = 1; target = 13'd55; tick();
        ret_int = 1; call = 1; target = 13'd700; tick();
        chk("R11", "call beats ret_int", int'(pc), 700);
        int_req = 1; int_vector = 13'd4; tick();
        chk("R7", "gie cleared", int'(gie), 0);
        call = 1; target = 13'd900; tick();
        ret_lit = 1; ret = 1; literal = 8'hA5; tick();
        chk("R6", "literal strobe", int'(w_load), 1);
        tick();
        chk("R6", "strobe one cycle", int'(w_load), 0);
        ret_int = 1; tick();
        chk("R8", "gie set", int'(gie), 1);
        ret_int = 1; tick();
        // Random overlapping strobes
        for (int n = 0; n < 6000; n++) begin
            if (n % 700 == 699) rst = 1;
            else rst = 0;
            int_req = ($urandom % 20) == 0;
            call    = ($urandom % 6) == 0;
            jump    = ($urandom % 10) == 0;
            ret_int = ($urandom % 12) == 0;
            ret_lit = ($urandom % 8) == 0;
            ret     = ($urandom % 5) == 0;
            step    = ($urandom % 2) == 0;
            target     = 13'($urandom);
            int_vector = 13'($urandom);
            literal    = 8'($urandom);
            tick();
        end
        rst = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule